// File: doc/BRIEF.md
# Sign-Magnitude Accumulator Processor with Interrupt Cycle

This block is a small 16-bit processor built around one accumulator. Each instruction word puts a 4-bit operation code in its top nibble and a 12-bit memory address in the lower bits. Data words are in sign-magnitude form. The core keeps a program counter, an instruction register, the accumulator, an interrupt-enable flag, a return-address register and a sticky overflow flag. Instructions and data share one synchronous memory of 4096 words held inside the block.

The sequencer steps through fetch, execute and interrupt-check phases. At each instruction boundary, and only while interrupts are enabled, it samples a level-sensitive request line. When that line is high the core spends one cycle on an interrupt entry. This cycle saves the address of the next instruction, clears the enable and jumps to a fixed handler address. A return instruction restores the saved address and sets the enable again.

A host port gives a second path into the same memory. Test equipment or a boot agent uses it to place a program and data while the core is held in reset, and to read results back after the core halts. Execution starts at a reset address placed above the handler area. The main program therefore never runs straight into the handler.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high and on the first cycle after it, pc_o reads the reset address 0x010, ac_o reads 0x0000, and ie_o, ovf_o and halted_o read 0.
- R2: Bits 15:12 of an instruction word hold the operation code and bits 11:0 hold the operand address. Each fetch loads the word at pc into the instruction register and adds one to pc. Code 0x0 and every unlisted code execute as no-ops.
- R3: Code 0x1 copies the memory word at the operand address into the accumulator.
- R4: Code 0x2 writes the accumulator to the operand address and leaves the accumulator unchanged.
- R5: Code 0x5 adds the memory word to the accumulator in sign-magnitude form: bit 15 is the sign (1 = negative) and bits 14:0 are the magnitude. With equal signs the magnitudes are summed. With unequal signs the smaller magnitude is taken from the larger and the larger one's sign is kept. A zero magnitude always gets sign 0.
- R6: A carry out of the 15-bit magnitude sum sets ovf_o and keeps only the low 15 magnitude bits. ovf_o stays set until reset.
- R7: The program 0x1940, 0x5941, 0x2941 at 0x300, with 3 at 0x940 and 2 at 0x941, writes 5 to 0x941. It leaves pc at 0x303 at the boundary after its third instruction, so a halt word at 0x303 stops the core with pc_o = 0x304.
- R8: Code 0xF stops the core. halted_o rises and stays high until reset, pc_o and ac_o hold their values, and no later word is executed.
- R9: Code 0xD sets the interrupt enable and code 0xE clears it. ie_o shows the enable.
- R10: After an instruction completes, if ie is 1 and irq is high, one entry cycle saves pc (the address of the following instruction), clears ie and loads pc with 0x001. While ie is 0, irq has no effect.
- R11: Code 0xC loads pc from the saved return address and sets ie. The interrupted program continues at the instruction after the one that completed before entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Level-sensitive interrupt request |
| host_we | input | 1 | Host write strobe into the memory |
| host_addr | input | 12 | Host memory address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle after the address |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| ie_o | output | 1 | Interrupt enable |
| ovf_o | output | 1 | Sticky magnitude overflow |
| halted_o | output | 1 | Core stopped by a halt instruction |

## Verification
Load and add take five cycles from fetch to the interrupt check. Store, enable, disable, return and no-op take four. Halt stops after three. An accepted interrupt adds one cycle, after which pc_o shows 0x001 with ie_o already low, and a host read returns data one clock after the address is driven. The bench never counts instruction cycles on its own. It drives inputs and samples outputs at falling edges and waits for halted_o or for pc_o to reach the vector, each wait bounded by a timeout. Memory is read only through the host port after the core has stopped, so every result is stable when it is sampled.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_NOP   = 4'h0;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h5;
  localparam logic [OPC_W-1:0] OPC_RETI  = 4'hC;
  localparam logic [OPC_W-1:0] OPC_IEN   = 4'hD;
  localparam logic [OPC_W-1:0] OPC_IDIS  = 4'hE;
  localparam logic [OPC_W-1:0] OPC_HALT  = 4'hF;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_IR    = 3'd1,
    ST_EXEC  = 3'd2,
    ST_MEMRD = 3'd3,
    ST_CHECK = 3'd4,
    ST_INT   = 3'd5,
    ST_HALT  = 3'd6
  } seq_state_e;

endpackage

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Two ports, registered reads, read-before-write on each port.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/acc_cpu_smadd.sv
module acc_cpu_smadd #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carry
);

  localparam int MW = W - 1;

  logic          sa, sb, sgn;
  logic [MW-1:0] ma, mb, mag;
  logic [MW:0]   wide;

  assign sa   = a[W-1];
  assign sb   = b[W-1];
  assign ma   = a[MW-1:0];
  assign mb   = b[MW-1:0];
  assign wide = {1'b0, ma} + {1'b0, mb};

  always_comb begin
    carry = 1'b0;
    if (sa == sb) begin
      mag   = wide[MW-1:0];
      sgn   = sa;
      carry = wide[MW];
    end else if (ma >= mb) begin
      mag = ma - mb;
      sgn = sa;
    end else begin
      mag = mb - ma;
      sgn = sb;
    end
    if (mag == '0) sgn = 1'b0;
    sum = {sgn, mag};
  end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] RESET_PC = 12'h010,
  parameter logic [ADDR_W-1:0] INT_VEC  = 12'h001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] add_sum,
  input  logic              add_carry,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ac,
  output logic              ie,
  output logic              ovf,
  output logic              halted,
  output seq_state_e        state
);

  localparam int CODE_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] ir;
  logic [ADDR_W-1:0] epc;
  logic [CODE_W-1:0] opc;
  logic [ADDR_W-1:0] opnd;

  assign opc  = ir[DATA_W-1 -: CODE_W];
  assign opnd = ir[ADDR_W-1:0];

  always_comb begin
    mem_addr  = pc;
    mem_we    = 1'b0;
    mem_wdata = ac;
    if (state == ST_EXEC) begin
      mem_addr = opnd;
      mem_we   = (opc == OPC_STORE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FETCH;
      pc     <= RESET_PC;
      ac     <= '0;
      ir     <= '0;
      epc    <= '0;
      ie     <= 1'b0;
      ovf    <= 1'b0;
      halted <= 1'b0;
    end else begin
      case (state)
        ST_FETCH: begin
          pc    <= pc + ADDR_W'(1);
          state <= ST_IR;
        end
        ST_IR: begin
          ir    <= mem_rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          state <= ST_CHECK;
          case (opc)
            OPC_LOAD, OPC_ADD: state <= ST_MEMRD;
            OPC_RETI: begin
              pc <= epc;
              ie <= 1'b1;
            end
            OPC_IEN:  ie <= 1'b1;
            OPC_IDIS: ie <= 1'b0;
            OPC_HALT: begin
              halted <= 1'b1;
              state  <= ST_HALT;
            end
            default: ;
          endcase
        end
        ST_MEMRD: begin
          if (opc == OPC_LOAD) begin
            ac <= mem_rdata;
          end else begin
            ac <= add_sum;
            if (add_carry) ovf <= 1'b1;
          end
          state <= ST_CHECK;
        end
        ST_CHECK: begin
          if (ie && irq) state <= ST_INT;
          else           state <= ST_FETCH;
        end
        ST_INT: begin
          epc   <= pc;
          pc    <= INT_VEC;
          ie    <= 1'b0;
          state <= ST_FETCH;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] RESET_PC = 12'h010,
  parameter logic [ADDR_W-1:0] INT_VEC  = 12'h001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ac_o,
  output logic              ie_o,
  output logic              ovf_o,
  output logic              halted_o
);

  logic [ADDR_W-1:0] core_addr;
  logic              core_we;
  logic [DATA_W-1:0] core_wdata;
  logic [DATA_W-1:0] core_rdata;
  logic [DATA_W-1:0] add_sum;
  logic              add_carry;
  seq_state_e        seq_state;

  acc_cpu_ram #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ram (
    .clk     (clk),
    .a_we    (core_we),
    .a_addr  (core_addr),
    .a_wdata (core_wdata),
    .a_rdata (core_rdata),
    .b_we    (host_we),
    .b_addr  (host_addr),
    .b_wdata (host_wdata),
    .b_rdata (host_rdata)
  );

  acc_cpu_smadd #(
    .W (DATA_W)
  ) u_add (
    .a     (ac_o),
    .b     (core_rdata),
    .sum   (add_sum),
    .carry (add_carry)
  );

  acc_cpu_seq #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .RESET_PC (RESET_PC),
    .INT_VEC  (INT_VEC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .mem_rdata (core_rdata),
    .add_sum   (add_sum),
    .add_carry (add_carry),
    .mem_addr  (core_addr),
    .mem_we    (core_we),
    .mem_wdata (core_wdata),
    .pc        (pc_o),
    .ac        (ac_o),
    .ie        (ie_o),
    .ovf       (ovf_o),
    .halted    (halted_o),
    .state     (seq_state)
  );

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int                DATA_W  = 16,
  parameter int                ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] INT_VEC = 12'h001
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input seq_state_e        state,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] ac,
  input logic              ie,
  input logic              ovf,
  input logic              halted
);

  // R2: every fetch advances pc by one
  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  // R6: overflow flag never drops without reset
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  // R8: a halted core keeps its state
  assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(ac)));

  // R10: entry only with enable set and a request seen at the check
  assert_int_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INT) |-> (ie && $past(irq)));

  // R10: entry lands on the vector with interrupts masked
  assert_int_vector_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INT) |=> (pc == INT_VEC && !ie));

  // R10: with the enable clear the check goes straight to fetch
  assert_int_masked_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CHECK && !ie) |=> (state == ST_FETCH));

endmodule

bind acc_cpu acc_cpu_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .INT_VEC (INT_VEC)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .irq    (irq),
  .state  (seq_state),
  .pc     (pc_o),
  .ac     (ac_o),
  .ie     (ie_o),
  .ovf    (ovf_o),
  .halted (halted_o)
);

// File: tb/acc_cpu_test.sv
module acc_cpu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [11:0] pc_o;
  logic [15:0] ac_o;
  logic        ie_o, ovf_o, halted_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  acc_cpu uut (
    .clk (clk), .rst (rst), .irq (irq),
    .host_we (host_we), .host_addr (host_addr), .host_wdata (host_wdata),
    .host_rdata (host_rdata), .pc_o (pc_o), .ac_o (ac_o), .ie_o (ie_o),
    .ovf_o (ovf_o), .halted_o (halted_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_to_halt(input string req, input int limit);
    bit done = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < limit && !done; i++) begin
      @(negedge clk);
      if (halted_o) done = 1'b1;
    end
    check({req, " halt reached"}, {15'd0, done}, 16'd1);
  endtask

  // R1
  task automatic t_reset();
    hold_reset();
    check("R1 pc", {4'd0, pc_o}, 16'h0010);
    check("R1 ac", ac_o, 16'h0000);
    check("R1 ie/ovf/halted", {13'd0, ie_o, ovf_o, halted_o}, 16'h0000);
  endtask

  // R2 R3 R4 R5 R7
  task automatic t_example();
    logic [15:0] v;
    hold_reset();
    for (int a = 12'h010; a < 12'h300; a++) wr(12'(a), 16'h0000);
    wr(12'h300, 16'h1940);
    wr(12'h301, 16'h5941);
    wr(12'h302, 16'h2941);
    wr(12'h303, 16'hF000);
    wr(12'h940, 16'h0003);
    wr(12'h941, 16'h0002);
    run_to_halt("R7", 6000);
    rd(12'h941, v);
    check("R7 sum stored (R4)", v, 16'h0005);
    rd(12'h940, v);
    check("R3 source intact", v, 16'h0003);
    check("R4 ac kept after store", ac_o, 16'h0005);
    check("R2/R7 pc one past halt", {4'd0, pc_o}, 16'h0304);
  endtask

  // R5 R6
  task automatic t_add(input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] exp, input logic exp_ovf);
    logic [15:0] v;
    hold_reset();
    wr(12'h010, 16'h10A0);
    wr(12'h011, 16'h50A1);
    wr(12'h012, 16'h20A2);
    wr(12'h013, 16'hF000);
    wr(12'h0A0, a);
    wr(12'h0A1, b);
    wr(12'h0A2, 16'hDEAD);
    run_to_halt("R5", 200);
    check("R5 add result", ac_o, exp);
    rd(12'h0A2, v);
    check("R5 stored result", v, exp);
    check("R6 overflow flag", {15'd0, ovf_o}, {15'd0, exp_ovf});
  endtask

  // R6
  task automatic t_sticky();
    hold_reset();
    wr(12'h010, 16'h10A0);
    wr(12'h011, 16'h50A1);
    wr(12'h012, 16'h50A1);
    wr(12'h013, 16'hF000);
    wr(12'h0A0, 16'h7FFF);
    wr(12'h0A1, 16'h0002);
    run_to_halt("R6", 200);
    check("R6 ac after wrap then add", ac_o, 16'h0003);
    check("R6 ovf stays set", {15'd0, ovf_o}, 16'h0001);
    hold_reset();
    check("R6 ovf cleared by reset", {15'd0, ovf_o}, 16'h0000);
  endtask

  // R8
  task automatic t_halt();
    logic [15:0] v;
    hold_reset();
    wr(12'h010, 16'h10D0);
    wr(12'h011, 16'hF000);
    wr(12'h012, 16'h20D1);
    wr(12'h013, 16'hF000);
    wr(12'h0D0, 16'h0042);
    wr(12'h0D1, 16'h1234);
    run_to_halt("R8", 200);
    repeat (20) @(negedge clk);
    check("R8 halted held", {15'd0, halted_o}, 16'h0001);
    check("R8 pc frozen", {4'd0, pc_o}, 16'h0012);
    check("R8 ac frozen", ac_o, 16'h0042);
    rd(12'h0D1, v);
    check("R8 word after halt not run", v, 16'h1234);
  endtask

  // R9
  task automatic t_ie();
    hold_reset();
    wr(12'h010, 16'hD000);
    wr(12'h011, 16'hF000);
    run_to_halt("R9", 200);
    check("R9 enable set", {15'd0, ie_o}, 16'h0001);
    hold_reset();
    wr(12'h010, 16'hD000);
    wr(12'h011, 16'hE000);
    wr(12'h012, 16'hF000);
    run_to_halt("R9", 200);
    check("R9 enable cleared", {15'd0, ie_o}, 16'h0000);
  endtask

  // R10 masked request
  task automatic t_masked();
    logic [15:0] v;
    hold_reset();
    wr(12'h001, 16'h10B0);
    wr(12'h002, 16'h20B1);
    wr(12'h003, 16'hF000);
    wr(12'h010, 16'h10B2);
    wr(12'h011, 16'h50B2);
    wr(12'h012, 16'h20B3);
    wr(12'h013, 16'hF000);
    wr(12'h0B0, 16'h0BAD);
    wr(12'h0B1, 16'h0000);
    wr(12'h0B2, 16'h0004);
    irq = 1'b1;
    run_to_halt("R10", 200);
    irq = 1'b0;
    rd(12'h0B1, v);
    check("R10 handler not entered while masked", v, 16'h0000);
    rd(12'h0B3, v);
    check("R10 main result with irq masked", v, 16'h0008);
    check("R10 pc with irq masked", {4'd0, pc_o}, 16'h0014);
  endtask

  // R10 R11 accepted request and return
  task automatic t_interrupt();
    logic [15:0] v;
    bit hit = 1'b0;
    hold_reset();
    wr(12'h001, 16'h10C0);
    wr(12'h002, 16'h20C1);
    wr(12'h003, 16'hC000);
    wr(12'h010, 16'hD000);
    wr(12'h011, 16'h10C2);
    wr(12'h012, 16'h20C3);
    wr(12'h013, 16'hF000);
    wr(12'h0C0, 16'h0011);
    wr(12'h0C1, 16'h0000);
    wr(12'h0C2, 16'h0022);
    wr(12'h0C3, 16'h0000);
    irq = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 100 && !hit; i++) begin
      @(negedge clk);
      if (pc_o == 12'h001) hit = 1'b1;
    end
    check("R10 vector reached", {15'd0, hit}, 16'h0001);
    check("R10 enable cleared on entry", {15'd0, ie_o}, 16'h0000);
    irq = 1'b0;
    for (int i = 0; i < 200 && !halted_o; i++) @(negedge clk);
    check("R11 halt reached after return", {15'd0, halted_o}, 16'h0001);
    rd(12'h0C1, v);
    check("R10 handler ran", v, 16'h0011);
    rd(12'h0C3, v);
    check("R11 resumed at following instruction", v, 16'h0022);
    check("R11 enable restored", {15'd0, ie_o}, 16'h0001);
    check("R11 pc after resume", {4'd0, pc_o}, 16'h0014);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_example();
    t_add(16'h0005, 16'h8003, 16'h0002, 1'b0);
    t_add(16'h8005, 16'h0003, 16'h8002, 1'b0);
    t_add(16'h8003, 16'h0003, 16'h0000, 1'b0);
    t_add(16'h8004, 16'h8004, 16'h8008, 1'b0);
    t_add(16'h7FFF, 16'h0002, 16'h0001, 1'b1);
    t_add(16'hC000, 16'hC000, 16'h0000, 1'b1);
    t_sticky();
    t_halt();
    t_ie();
    t_masked();
    t_interrupt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule